// File: doc/BRIEF.md
# Commit-Point Trap and Interrupt Controller

This block sits at the last stage of an in-order pipeline and decides what happens to the instruction arriving there. Each pipeline stage may have flagged an exception code for the instruction. The block keeps the code from the earliest stage that flagged one. It also looks at an external interrupt request line, and at this point only. From these inputs it decides whether the instruction commits, whether its scoreboard entry is freed, and whether fetch must be sent to the trap handler or back to the saved return address.

The block holds four pieces of architectural state: the saved return PC, the trap cause code, the privilege mode and the interrupt-enable flag. These registers are written at the clock edge that ends the commit cycle. The commit, scoreboard-remove and redirect outputs are combinational in the commit cycle. The redirect is a single-cycle valid together with a target PC, and the epoch logic in fetch consumes it.

Top module: `commit_trap_unit`

## Requirements
- R1: After reset the saved PC is 0, the cause code is 0, the mode is user (privMode=0) and interrupts are enabled (irqEnable=1).
- R2: Stage causes are merged with the lowest stage index as the earliest stage. The earliest stage with its valid bit set supplies the 4-bit cause code, and later stages never override it. Codes: 0 multiply fault, 1 illegal opcode, 2 overflow, 3 instruction-address fault, 4 data-address fault, 15 external.
- R3: A valid instruction with no cause, not an exception-return, and no interrupt taken asserts commit and sbRemove, gives no redirect and leaves all four registers unchanged.
- R4: If an interrupt is taken (extIrq, irqEnable and instValid all high) for an instruction with no cause that is not an exception-return, the instruction commits with sbRemove. The saved PC becomes instPredPc, the cause becomes 15, and a redirect to the handler PC 0x1004 is issued.
- R5: If an interrupt is taken for an instruction that has a cause, the instruction does not commit. The saved PC becomes instPc and the cause becomes 15, overriding the instruction's own code, and a redirect to 0x1004 is issued.
- R6: With no interrupt taken, an instruction with a cause does not commit. The cause register takes the merged code and a redirect to 0x1004 is issued. The saved PC becomes instPc+4 for code 0 (a fault; the instruction counts as done) and instPc for every other code (the instruction will be re-executed).
- R7: Every redirect to the handler sets privMode to 1 and clears irqEnable.
- R8: On an instruction with a cause, sbRemove is asserted only when the winning stage index is at least 2 (the cause arose after register fetch).
- R9: An exception-return with no cause and no interrupt taken commits with sbRemove. It redirects to the saved PC as it was in that cycle, sets privMode to 0 and sets irqEnable to 1.
- R10: While irqEnable is 0, extIrq has no effect: a clean instruction commits with no redirect and no change to the registers.
- R11: While instValid is low, no strobe or redirect is issued and no register changes, whatever extIrq is.
- R12: If an interrupt is taken for an exception-return with no cause, the return is not performed. The instruction does not commit, sbRemove stays low, the saved PC becomes instPc and the cause becomes 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is present at commit |
| instPc | input | 32 | PC of the instruction at commit |
| instPredPc | input | 32 | Predicted next PC of that instruction |
| stageCauseValid | input | 4 | Per-stage cause flags, bit 0 is the earliest stage |
| stageCause | input | 16 | Per-stage 4-bit cause codes, stage s in bits [4s+3:4s] |
| instIsEret | input | 1 | The instruction is an exception-return |
| extIrq | input | 1 | External interrupt request |
| commit | output | 1 | The instruction commits this cycle |
| sbRemove | output | 1 | Free the instruction's scoreboard entry |
| redirectValid | output | 1 | Single-cycle redirect strobe |
| redirectPc | output | 32 | Redirect target |
| epc | output | 32 | Saved return PC |
| causeCode | output | 4 | Trap cause register |
| privMode | output | 1 | 1 = privileged, 0 = user |
| irqEnable | output | 1 | Interrupt enable |

## Verification
The bench sweeps every combination of the stage-cause flags, with varied codes, interrupt present or absent, and exception-return or plain instruction. It compares each case against an arithmetic model of the rules. The cases it targets are these:
- A later stage overwriting an earlier cause, which shows up as a wrong cause code.
- The interrupt failing to override the instruction's own cause, which leaves the wrong code and the wrong saved PC.
- The fault and exception saved PCs swapped, which is off by 4.
- Scoreboard release tied to the wrong stage boundary.
- A masked interrupt or an idle cycle still trapping.
- An exception-return that is honoured even though an interrupt is taken in the same cycle.

// File: rtl/commit_trap_pkg.sv
package commit_trap_pkg;
  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_MULT = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_EXT  = 4'd15;

  typedef enum logic [1:0] {
    EPC_PC   = 2'd0,
    EPC_PC4  = 2'd1,
    EPC_PRED = 2'd2
  } epcSel_e;

  typedef struct packed {
    logic    commit;
    logic    sbRemove;
    logic    trap;
    logic    eret;
    epcSel_e epcSel;
    logic    causeExt;
  } ctrlStrobe_t;
endpackage

// File: rtl/cause_merge.sv
module cause_merge #(
  parameter int NSTAGE = 4,
  parameter int LATE_STAGE = 2,
  parameter int CW = 4
) (
  input  logic [NSTAGE-1:0]    stageValid,
  input  logic [NSTAGE*CW-1:0] stageCode,
  output logic                 anyValid,
  output logic [CW-1:0]        mergedCode,
  output logic                 lateCause
);
  always_comb begin
    anyValid   = 1'b0;
    mergedCode = '0;
    lateCause  = 1'b0;
    for (int s = NSTAGE - 1; s >= 0; s--) begin
      if (stageValid[s]) begin
        anyValid   = 1'b1;
        mergedCode = stageCode[s*CW +: CW];
        lateCause  = (s >= LATE_STAGE);
      end
    end
  end

  always_comb begin
    if (stageValid[0]) assert (mergedCode == stageCode[CW-1:0]); // R2
  end
endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl
  import commit_trap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic        instIsEret,
  input  logic        extIrq,
  input  logic        irqEnable,
  input  logic        causeValid,
  input  logic [3:0]  causeCode,
  input  logic        lateCause,
  output ctrlStrobe_t strb
);
  logic takeIrq;
  assign takeIrq = instValid && extIrq && irqEnable;

  always_comb begin
    strb = '{commit: 1'b0, sbRemove: 1'b0, trap: 1'b0, eret: 1'b0,
             epcSel: EPC_PC, causeExt: 1'b0};
    if (instValid) begin
      if (takeIrq) begin
        strb.trap     = 1'b1;
        strb.causeExt = 1'b1;
        if (causeValid || instIsEret) begin
          strb.epcSel   = EPC_PC;
          strb.sbRemove = causeValid && lateCause;
        end else begin
          strb.commit   = 1'b1;
          strb.sbRemove = 1'b1;
          strb.epcSel   = EPC_PRED;
        end
      end else if (causeValid) begin
        strb.trap     = 1'b1;
        strb.sbRemove = lateCause;
        strb.epcSel   = (causeCode == CAUSE_MULT) ? EPC_PC4 : EPC_PC;
      end else begin
        strb.commit   = 1'b1;
        strb.sbRemove = 1'b1;
        strb.eret     = instIsEret;
      end
    end
  end

  AST_ONE_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.trap, strb.eret})); // R12
  AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !irqEnable && !causeValid && !instIsEret) |-> (strb.commit && !strb.trap)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> (strb == '0)); // R11
endmodule

// File: rtl/commit_dp.sv
module commit_dp
  import commit_trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h1004
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strb,
  input  logic [XLEN-1:0] instPc,
  input  logic [XLEN-1:0] instPredPc,
  input  logic [3:0]      mergedCode,
  output logic [XLEN-1:0] epc,
  output logic [3:0]      causeCode,
  output logic            privMode,
  output logic            irqEnable,
  output logic            redirectValid,
  output logic [XLEN-1:0] redirectPc
);
  logic [XLEN-1:0] epcNext;

  always_comb begin
    case (strb.epcSel)
      EPC_PC4:  epcNext = instPc + XLEN'(4);
      EPC_PRED: epcNext = instPredPc;
      default:  epcNext = instPc;
    endcase
  end

  assign redirectValid = strb.trap || strb.eret;
  assign redirectPc    = strb.trap ? HANDLER_PC : epc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epc       <= '0;
      causeCode <= '0;
      privMode  <= 1'b0;
      irqEnable <= 1'b1;
    end else if (strb.trap) begin
      epc       <= epcNext;
      causeCode <= strb.causeExt ? CAUSE_EXT : mergedCode;
      privMode  <= 1'b1;
      irqEnable <= 1'b0;
    end else if (strb.eret) begin
      privMode  <= 1'b0;
      irqEnable <= 1'b1;
    end
  end

  AST_TRAP_PRIV: assert property (@(posedge clk) disable iff (!rstN)
    strb.trap |=> (privMode && !irqEnable)); // R7
  AST_ERET_USER: assert property (@(posedge clk) disable iff (!rstN)
    strb.eret |=> (!privMode && irqEnable)); // R9
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rstN)
    !redirectValid |=> ($stable(epc) && $stable(causeCode) && $stable(privMode))); // R3
endmodule

// File: rtl/commit_trap_unit.sv
module commit_trap_unit
  import commit_trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NSTAGE = 4,
  parameter int LATE_STAGE = 2,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h1004
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  instValid,
  input  logic [XLEN-1:0]       instPc,
  input  logic [XLEN-1:0]       instPredPc,
  input  logic [NSTAGE-1:0]     stageCauseValid,
  input  logic [NSTAGE*4-1:0]   stageCause,
  input  logic                  instIsEret,
  input  logic                  extIrq,
  output logic                  commit,
  output logic                  sbRemove,
  output logic                  redirectValid,
  output logic [XLEN-1:0]       redirectPc,
  output logic [XLEN-1:0]       epc,
  output logic [3:0]            causeCode,
  output logic                  privMode,
  output logic                  irqEnable
);
  logic        causeValid;
  logic [3:0]  mergedCode;
  logic        lateCause;
  ctrlStrobe_t strb;

  cause_merge #(.NSTAGE(NSTAGE), .LATE_STAGE(LATE_STAGE), .CW(CAUSE_W)) i_merge (
    .stageValid(stageCauseValid), .stageCode(stageCause),
    .anyValid(causeValid), .mergedCode(mergedCode), .lateCause(lateCause));

  commit_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instIsEret(instIsEret),
    .extIrq(extIrq), .irqEnable(irqEnable), .causeValid(causeValid),
    .causeCode(mergedCode), .lateCause(lateCause), .strb(strb));

  commit_dp #(.XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .instPc(instPc), .instPredPc(instPredPc),
    .mergedCode(mergedCode), .epc(epc), .causeCode(causeCode), .privMode(privMode),
    .irqEnable(irqEnable), .redirectValid(redirectValid), .redirectPc(redirectPc));

  assign commit   = strb.commit;
  assign sbRemove = strb.sbRemove;
endmodule

// File: tb/test_commit_trap_unit.sv
module test_commit_trap_unit;
  logic        clk = 0;
  logic        rstN = 0;
  logic        instValid = 0;
  logic [31:0] instPc = 0, instPredPc = 0;
  logic [3:0]  stageCauseValid = 0;
  logic [15:0] stageCause = 0;
  logic        instIsEret = 0, extIrq = 0;
  logic        commit, sbRemove, redirectValid, privMode, irqEnable;
  logic [31:0] redirectPc, epc;
  logic [3:0]  causeCode;

  int nRun = 0, nFail = 0;
  bit done = 0;
  logic [31:0] mEpc;
  logic [3:0]  mCause;
  logic        mPriv, mIe;

  always #5 clk = ~clk;

  commit_trap_unit i_commit_trap_unit (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkRegs(input string tag);
    chk(tag, epc, mEpc, "epc");
    chk(tag, {28'd0, causeCode}, {28'd0, mCause}, "cause");
    chk(tag, {31'd0, privMode}, {31'd0, mPriv}, "priv");
    chk(tag, {31'd0, irqEnable}, {31'd0, mIe}, "irqEnable");
  endtask

  task automatic runInst(input logic v, input logic [31:0] pc, input logic [31:0] pred,
                         input logic [3:0] mask, input logic [15:0] codes,
                         input logic er, input logic ext);
    logic has, late, take, eCommit, eSb, eRedir;
    logic [3:0] code;
    logic [31:0] eRpc;
    string tag;
    has = 0; late = 0; code = 0;
    for (int s = 3; s >= 0; s--)
      if (mask[s]) begin has = 1; code = codes[s*4 +: 4]; late = (s >= 2); end
    take = v && ext && mIe;
    eCommit = 0; eSb = 0; eRedir = 0; eRpc = 32'h1004;
    tag = "R11";
    if (v) begin
      if (take) begin
        eRedir = 1;
        if (has || er) begin
          tag = has ? "R5" : "R12";
          eSb = has && late;
        end else begin
          tag = "R4"; eCommit = 1; eSb = 1;
        end
      end else if (has) begin
        tag = late ? "R8" : "R6"; eRedir = 1; eSb = late;
      end else begin
        eCommit = 1; eSb = 1;
        if (er) begin tag = "R9"; eRedir = 1; eRpc = mEpc; end
        else tag = (ext && !mIe) ? "R10" : "R3";
      end
    end
    @(negedge clk);
    instValid = v; instPc = pc; instPredPc = pred; stageCauseValid = mask;
    stageCause = codes; instIsEret = er; extIrq = ext;
    #2;
    chk(tag, {31'd0, commit}, {31'd0, eCommit}, "commit");
    chk(tag, {31'd0, sbRemove}, {31'd0, eSb}, "sbRemove");
    chk(tag, {31'd0, redirectValid}, {31'd0, eRedir}, "redirectValid");
    if (eRedir) chk(tag, redirectPc, eRpc, "redirectPc");
    if (take) begin
      mEpc = (has || er) ? pc : pred; mCause = 4'd15; mPriv = 1; mIe = 0;
    end else if (v && has) begin
      mEpc = (code == 0) ? pc + 32'd4 : pc; mCause = code; mPriv = 1; mIe = 0;
      if (code != 15) tag = (code == 0 || late) ? "R6" : "R2";
    end else if (v && er) begin
      mPriv = 0; mIe = 1;
    end
    if (eRedir && !(v && er && !has && !take)) tag = "R7";
    @(posedge clk); #1;
    checkRegs(tag);
  endtask

  initial begin
    mEpc = 0; mCause = 0; mPriv = 0; mIe = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1 checkRegs("R1");
    runInst(1, 32'h100, 32'h104, 4'b0000, 16'h0, 0, 0);
    for (int mask = 0; mask < 16; mask++)
      for (int ext = 0; ext < 2; ext++)
        for (int er = 0; er < 2; er++) begin
          logic [15:0] codes;
          for (int s = 0; s < 4; s++) codes[s*4 +: 4] = 4'((mask + 3 * s + ext) % 5);
          runInst(1, 32'h2000 + 32'(mask * 16), 32'h3000 + 32'(mask * 8),
                  4'(mask), codes, 1'(er), 1'(ext));
          if (!mIe) begin
            runInst(1, 32'h500, 32'h504, 4'b0000, 16'h0, 0, 1);
            runInst(0, 32'h600, 32'h604, 4'b0001, 16'h1, 0, 1);
            runInst(1, 32'h700, 32'h704, 4'b0000, 16'h0, 1, 0);
          end
          runInst(0, 32'h800, 32'h804, 4'b1111, 16'h4321, 1, 1);
        end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule